// File: doc/BRIEF.md
# SCL Clock Timing Generator

This block produces the serial clock for a two-wire bus controller acting as the bus master. It drives an open-drain clock line: a single enable output pulls the line low, and releasing it lets the pull-up raise the line. The low and high phases are timed in reference clock cycles from six count inputs, one high/low pair for each of the standard, fast and high-speed modes, chosen by a 2-bit speed mode. The low phase adds one fixed cycle to its count. The high phase adds the active spike-filter length plus seven fixed cycles to its count, and it does not start counting until the filtered clock line actually reads high. A target that holds the line low therefore stretches the clock.

The sampled clock and data inputs each pass through a counter-based glitch filter whose length is the standard spike length in standard and fast modes and a separate high-speed spike length in high-speed mode. Two single-cycle strobes tell the byte engine when to act. One strobe marks the point to change data, a transmit hold delay after the clock is pulled low. The other marks the point to sample data, a receive hold delay after the high phase begins. The inputs are taken to be synchronous to the reference clock already.

Top module: `scl_timing_gen`

## Requirements
- R1: During and after a synchronous reset with `enable` low, `scl_oe` is 0, `scl_filt` and `sda_filt` are 1, and `tx_strobe` and `rx_strobe` are 0.
- R2: `speed_mode` picks the count pair. The value 0 selects the standard pair, 1 selects the fast pair and 2 selects the high-speed pair. The value 3 behaves like 0.
- R3: Each low phase holds `scl_oe` at 1 for exactly the selected low count plus 1 consecutive cycles.
- R4: In each released phase that follows a low phase, the number of cycles with `scl_oe` at 0 and `scl_filt` at 1 equals the selected high count plus the active spike length plus 8. This is one sensing cycle followed by a counted high phase of count + spike + 7.
- R5: The active spike length is `hs_spike_len` when `speed_mode` is 2, and `spike_len` otherwise. It applies to both the clock filter and the data filter.
- R6: A filtered output takes a new raw value only after that value has been sampled on more than the active spike length consecutive clock edges. It changes on the (length+1)-th such edge. A pulse of at most the spike length in samples never reaches the output.
- R7: While the released clock line is held low by a target, `scl_oe` stays 0 and the high-phase count waits. The high-phase window of R4 is unchanged by the stretch.
- R8: `tx_strobe` is a one-cycle pulse in the cycle whose index equals `sda_hold[15:0]` within the low phase, where the first cycle with `scl_oe` at 1 has index 0.
- R9: `rx_strobe` is a one-cycle pulse in the cycle whose index equals `sda_hold[23:16]` + 1 within the released phase, where the first cycle in which `scl_filt` reads 1 has index 0.
- R10: A low phase starts only when `enable` is 1. When `enable` is 0 at the end of a high phase, the clock stays released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the clock generator |
| speed_mode | input | 2 | 0 standard, 1 fast, 2 high speed, 3 as standard |
| ss_hcnt | input | 16 | Standard-mode high count |
| ss_lcnt | input | 16 | Standard-mode low count |
| fs_hcnt | input | 16 | Fast-mode high count |
| fs_lcnt | input | 16 | Fast-mode low count |
| hs_hcnt | input | 16 | High-speed high count |
| hs_lcnt | input | 16 | High-speed low count |
| spike_len | input | 8 | Spike length for standard and fast modes |
| hs_spike_len | input | 8 | Spike length for high-speed mode |
| sda_hold | input | 24 | [15:0] transmit hold, [23:16] receive hold, in cycles |
| scl_in | input | 1 | Raw sampled clock line |
| sda_in | input | 1 | Raw sampled data line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| scl_filt | output | 1 | Filtered clock line |
| sda_filt | output | 1 | Filtered data line |
| tx_strobe | output | 1 | Change-data pulse |
| rx_strobe | output | 1 | Sample-data pulse |

## Verification
On every cycle the assertions check several things. The length of every low run against the selected count and the length of every sensed-high window against count, spike and overhead are both checked. They also check that a filtered output only ever moves to the value the raw input had on the edge before, and that no low phase begins without `enable`. Other behaviour appears only in the bench's scenarios. This covers where exactly the two strobes land, the rejection of short data pulses next to the acceptance latency of long ones, the switch to the high-speed spike length, a target stretching the clock, and the line staying released after `enable` drops.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    localparam int CNT_W    = 16;
    localparam int SPK_W    = 8;
    localparam int TXH_W    = 16;
    localparam int RXH_W    = 8;
    localparam int HIGH_OVH = 7;
    localparam int LOW_OVH  = 1;
    localparam int PH_W     = CNT_W + 1;

    typedef enum logic [1:0] {
        SPD_STD  = 2'd0,
        SPD_FAST = 2'd1,
        SPD_HIGH = 2'd2,
        SPD_RSVD = 2'd3
    } speed_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_WAIT,
        PH_HIGH
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] hcnt;
        logic [CNT_W-1:0] lcnt;
        logic [SPK_W-1:0] spk;
    } phase_cfg_t;

    // Reserved mode falls back to the standard pair.
    function automatic phase_cfg_t pick_cfg(
        input speed_e           mode,
        input logic [CNT_W-1:0] ss_h, input logic [CNT_W-1:0] ss_l,
        input logic [CNT_W-1:0] fs_h, input logic [CNT_W-1:0] fs_l,
        input logic [CNT_W-1:0] hs_h, input logic [CNT_W-1:0] hs_l,
        input logic [SPK_W-1:0] spk_n, input logic [SPK_W-1:0] spk_h
    );
        phase_cfg_t c;
        case (mode)
            SPD_FAST: c = '{hcnt: fs_h, lcnt: fs_l, spk: spk_n};
            SPD_HIGH: c = '{hcnt: hs_h, lcnt: hs_l, spk: spk_h};
            default:  c = '{hcnt: ss_h, lcnt: ss_l, spk: spk_n};
        endcase
        return c;
    endfunction

    // Last counter value of the counted high phase.
    function automatic logic [PH_W-1:0] high_last(input phase_cfg_t c);
        return PH_W'(c.hcnt) + PH_W'(c.spk) + PH_W'(HIGH_OVH) - PH_W'(1);
    endfunction

    // Last counter value of the low phase.
    function automatic logic [PH_W-1:0] low_last(input phase_cfg_t c);
        return PH_W'(c.lcnt) + PH_W'(LOW_OVH) - PH_W'(1);
    endfunction

endpackage

// File: rtl/scl_glitch_filter.sv
module scl_glitch_filter #(
    parameter int LEN_W     = 8,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] len,
    input  logic             raw,
    output logic             clean
);

    logic [LEN_W-1:0] run_q;

    // The output flips once the differing input has been sampled len+1 times.
    always_ff @(posedge clk) begin
        if (rst) begin
            clean <= RESET_VAL;
            run_q <= '0;
        end else if (raw == clean) begin
            run_q <= '0;
        end else if (run_q == len) begin
            clean <= raw;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

endmodule

// File: rtl/scl_strobe_delay.sv
module scl_strobe_delay #(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [HOLD_W-1:0] hold,
    output logic              strobe
);

    logic              armed_q;
    logic [HOLD_W-1:0] left_q;

    assign strobe = armed_q && (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            left_q  <= '0;
        end else if (start) begin
            armed_q <= 1'b1;
            left_q  <= hold;
        end else if (armed_q) begin
            if (left_q == '0) armed_q <= 1'b0;
            else              left_q  <= left_q - 1'b1;
        end
    end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_timing_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  phase_cfg_t cfg,
    input  logic       line_high,
    output logic       drive_low,
    output logic       low_begin,
    output logic       high_begin
);

    phase_e          st_q, st_d;
    logic [PH_W-1:0] cnt_q;
    logic [PH_W-1:0] hi_end, lo_end;

    assign hi_end = high_last(cfg);
    assign lo_end = low_last(cfg);

    always_comb begin
        st_d = st_q;
        case (st_q)
            PH_IDLE: if (enable)          st_d = PH_LOW;
            PH_LOW:  if (cnt_q == lo_end) st_d = PH_WAIT;
            PH_WAIT: if (line_high)       st_d = PH_HIGH;
            PH_HIGH: if (cnt_q == hi_end) st_d = enable ? PH_LOW : PH_IDLE;
            default:                      st_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d != st_q || st_q == PH_IDLE || st_q == PH_WAIT)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign drive_low  = (st_q == PH_LOW);
    assign low_begin  = (st_q != PH_LOW) && (st_d == PH_LOW);
    assign high_begin = (st_q == PH_WAIT) && (st_d == PH_HIGH);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         enable,
    input  logic [1:0]                   speed_mode,
    input  logic [CNT_W-1:0]             ss_hcnt,
    input  logic [CNT_W-1:0]             ss_lcnt,
    input  logic [CNT_W-1:0]             fs_hcnt,
    input  logic [CNT_W-1:0]             fs_lcnt,
    input  logic [CNT_W-1:0]             hs_hcnt,
    input  logic [CNT_W-1:0]             hs_lcnt,
    input  logic [SPK_W-1:0]             spike_len,
    input  logic [SPK_W-1:0]             hs_spike_len,
    input  logic [TXH_W+RXH_W-1:0]       sda_hold,
    input  logic                         scl_in,
    input  logic                         sda_in,
    output logic                         scl_oe,
    output logic                         scl_filt,
    output logic                         sda_filt,
    output logic                         tx_strobe,
    output logic                         rx_strobe
);

    localparam int N_LINES = 2;

    phase_cfg_t         cfg;
    logic [N_LINES-1:0] raw_lines, clean_lines;
    logic               low_begin, high_begin;

    assign cfg = pick_cfg(speed_e'(speed_mode), ss_hcnt, ss_lcnt, fs_hcnt, fs_lcnt,
                          hs_hcnt, hs_lcnt, spike_len, hs_spike_len);

    // Line 0 is the clock, line 1 is the data.
    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        scl_glitch_filter #(
            .LEN_W     (SPK_W),
            .RESET_VAL (1'b1)
        ) i_filt (
            .clk   (clk),
            .rst   (rst),
            .len   (cfg.spk),
            .raw   (raw_lines[g]),
            .clean (clean_lines[g])
        );
    end

    assign scl_filt = clean_lines[0];
    assign sda_filt = clean_lines[1];

    scl_phase_fsm i_fsm (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .cfg        (cfg),
        .line_high  (scl_filt),
        .drive_low  (scl_oe),
        .low_begin  (low_begin),
        .high_begin (high_begin)
    );

    scl_strobe_delay #(.HOLD_W(TXH_W)) i_tx_dly (
        .clk    (clk),
        .rst    (rst),
        .start  (low_begin),
        .hold   (sda_hold[TXH_W-1:0]),
        .strobe (tx_strobe)
    );

    scl_strobe_delay #(.HOLD_W(RXH_W)) i_rx_dly (
        .clk    (clk),
        .rst    (rst),
        .start  (high_begin),
        .hold   (sda_hold[TXH_W+RXH_W-1:TXH_W]),
        .strobe (rx_strobe)
    );

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk
    import scl_timing_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic [1:0]       speed_mode,
    input logic [CNT_W-1:0] ss_hcnt,
    input logic [CNT_W-1:0] ss_lcnt,
    input logic [CNT_W-1:0] fs_hcnt,
    input logic [CNT_W-1:0] fs_lcnt,
    input logic [CNT_W-1:0] hs_hcnt,
    input logic [CNT_W-1:0] hs_lcnt,
    input logic [SPK_W-1:0] spike_len,
    input logic [SPK_W-1:0] hs_spike_len,
    input logic             scl_in,
    input logic             sda_in,
    input logic             scl_oe,
    input logic             scl_filt,
    input logic             sda_filt
);

    localparam int RUN_W = CNT_W + 2;

    logic [CNT_W-1:0] exp_h, exp_l;
    logic [SPK_W-1:0] exp_k;
    logic [RUN_W-1:0] lo_run, hi_run;
    logic             seen_low;

    always_comb begin
        case (speed_mode)
            2'd1:    begin exp_h = fs_hcnt; exp_l = fs_lcnt; exp_k = spike_len;    end
            2'd2:    begin exp_h = hs_hcnt; exp_l = hs_lcnt; exp_k = hs_spike_len; end
            default: begin exp_h = ss_hcnt; exp_l = ss_lcnt; exp_k = spike_len;    end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_run   <= '0;
            hi_run   <= '0;
            seen_low <= 1'b0;
        end else begin
            lo_run <= scl_oe ? lo_run + 1'b1 : '0;
            if (!enable) seen_low <= 1'b0;
            else if (scl_oe) seen_low <= 1'b1;
            if (scl_oe || !enable)
                hi_run <= '0;
            else if (scl_filt && seen_low)
                hi_run <= hi_run + 1'b1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) rst |=> (!scl_oe && scl_filt && sda_filt));

    // R3
    low_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!scl_oe && lo_run != '0) |-> (lo_run == RUN_W'(exp_l) + RUN_W'(1)));

    // R4
    high_len_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_oe && hi_run != '0) |-> (hi_run == RUN_W'(exp_h) + RUN_W'(exp_k) + RUN_W'(8)));

    // R6
    scl_filt_src_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(scl_filt) |-> (scl_filt == $past(scl_in)));

    // R6
    sda_filt_src_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_filt) |-> (sda_filt == $past(sda_in)));

    // R10
    start_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_oe) |-> $past(enable));

endmodule

bind scl_timing_gen scl_timing_gen_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .speed_mode   (speed_mode),
    .ss_hcnt      (ss_hcnt),
    .ss_lcnt      (ss_lcnt),
    .fs_hcnt      (fs_hcnt),
    .fs_lcnt      (fs_lcnt),
    .hs_hcnt      (hs_hcnt),
    .hs_lcnt      (hs_lcnt),
    .spike_len    (spike_len),
    .hs_spike_len (hs_spike_len),
    .scl_in       (scl_in),
    .sda_in       (sda_in),
    .scl_oe       (scl_oe),
    .scl_filt     (scl_filt),
    .sda_filt     (sda_filt)
);

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [1:0]  speed_mode = 2'd0;
    logic [15:0] ss_hcnt = 16'd20, ss_lcnt = 16'd30;
    logic [15:0] fs_hcnt = 16'd10, fs_lcnt = 16'd14;
    logic [15:0] hs_hcnt = 16'd2,  hs_lcnt = 16'd6;
    logic [7:0]  spike_len = 8'd2, hs_spike_len = 8'd1;
    logic [23:0] sda_hold = 24'h02_0003;
    logic        stretch = 1'b0;
    logic        sda_in = 1'b1;
    logic        scl_in, scl_oe, scl_filt, sda_filt, tx_strobe, rx_strobe;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    // Open-drain clock line with a target that may hold it low.
    assign scl_in = ~scl_oe & ~stretch;

    scl_timing_gen i_scl_timing_gen (
        .clk(clk), .rst(rst), .enable(enable), .speed_mode(speed_mode),
        .ss_hcnt(ss_hcnt), .ss_lcnt(ss_lcnt), .fs_hcnt(fs_hcnt), .fs_lcnt(fs_lcnt),
        .hs_hcnt(hs_hcnt), .hs_lcnt(hs_lcnt), .spike_len(spike_len),
        .hs_spike_len(hs_spike_len), .sda_hold(sda_hold), .scl_in(scl_in),
        .sda_in(sda_in), .scl_oe(scl_oe), .scl_filt(scl_filt), .sda_filt(sda_filt),
        .tx_strobe(tx_strobe), .rx_strobe(rx_strobe)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  spk;
        logic [7:0]  hspk;
        logic [15:0] e_low;
        logic [15:0] e_high;
    } vec_t;

    // Counts: std 20/30, fast 10/14, high 2/6; tx hold 3, rx hold 2.
    localparam vec_t VECS [6] = '{
        '{2'd0, 8'd2, 8'd1, 16'd31, 16'd30},
        '{2'd1, 8'd4, 8'd1, 16'd15, 16'd22},
        '{2'd2, 8'd4, 8'd1, 16'd7,  16'd11},
        '{2'd3, 8'd0, 8'd1, 16'd31, 16'd28},
        '{2'd1, 8'd0, 8'd3, 16'd15, 16'd18},
        '{2'd2, 8'd0, 8'd3, 16'd7,  16'd13}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // One period: low length, tx strobe index, sensed-high length, rx strobe index.
    task automatic measure(output int lo, output int tx_i, output int hi, output int rx_i);
        lo = 0; tx_i = -1; hi = 0; rx_i = -1;
        while (!scl_oe) @(negedge clk);
        while (scl_oe) begin
            if (tx_strobe && tx_i < 0) tx_i = lo;
            lo++;
            @(negedge clk);
        end
        while (!scl_oe) begin
            if (scl_filt) begin
                if (rx_strobe && rx_i < 0) rx_i = hi;
                hi++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        int lo, tx_i, hi, rx_i, bad, k;

        // R1 reset state, R10 no start while enable is low
        do_reset();
        @(negedge clk);
        check("R1 scl_oe", int'(scl_oe), 0);
        check("R1 scl_filt", int'(scl_filt), 1);
        check("R1 sda_filt", int'(sda_filt), 1);
        check("R1 tx_strobe", int'(tx_strobe), 0);
        check("R1 rx_strobe", int'(rx_strobe), 0);
        bad = 0;
        repeat (50) begin @(negedge clk); if (scl_oe) bad++; end
        check("R10 idle without enable", bad, 0);

        // R2 R3 R4 R5 R8 R9 vector walk
        foreach (VECS[i]) begin
            rst = 1'b1;
            speed_mode   = VECS[i].mode;
            spike_len    = VECS[i].spk;
            hs_spike_len = VECS[i].hspk;
            sda_hold     = 24'h02_0003;
            do_reset();
            enable = 1'b1;
            measure(lo, tx_i, hi, rx_i);
            check("R2 R3 first low", lo, int'(VECS[i].e_low));
            measure(lo, tx_i, hi, rx_i);
            check("R2 R3 low", lo, int'(VECS[i].e_low));
            check("R4 R5 high window", hi, int'(VECS[i].e_high));
            check("R8 tx index", tx_i, 3);
            check("R9 rx index", rx_i, 3);
            enable = 1'b0;
        end

        // R8 R9 zero hold
        rst = 1'b1;
        speed_mode = 2'd1; spike_len = 8'd0; sda_hold = 24'h00_0000;
        do_reset();
        enable = 1'b1;
        measure(lo, tx_i, hi, rx_i);
        measure(lo, tx_i, hi, rx_i);
        check("R8 tx index hold0", tx_i, 0);
        check("R9 rx index hold0", rx_i, 1);
        enable = 1'b0;

        // R6 data spike filter, standard spike length 3
        rst = 1'b1;
        speed_mode = 2'd0; spike_len = 8'd3; hs_spike_len = 8'd1; sda_hold = 24'h02_0003;
        do_reset();
        @(negedge clk);
        bad = 0;
        sda_in = 1'b0;
        for (int i = 0; i < 3; i++) begin @(negedge clk); if (!sda_filt) bad++; end
        sda_in = 1'b1;
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (!sda_filt) bad++; end
        check("R6 short pulse ignored", bad, 0);
        sda_in = 1'b0; k = 0;
        do begin @(negedge clk); k++; end while (sda_filt && k < 50);
        check("R6 accept latency", k, 4);
        sda_in = 1'b1;
        repeat (10) @(negedge clk);
        check("R6 back high", int'(sda_filt), 1);

        // R5 high-speed mode uses hs_spike_len for the data filter
        rst = 1'b1;
        speed_mode = 2'd2; spike_len = 8'd5; hs_spike_len = 8'd1;
        do_reset();
        @(negedge clk);
        sda_in = 1'b0; k = 0;
        do begin @(negedge clk); k++; end while (sda_filt && k < 50);
        check("R5 hs spike latency", k, 2);
        sda_in = 1'b1;
        repeat (10) @(negedge clk);

        // R7 clock stretching
        rst = 1'b1;
        speed_mode = 2'd0; spike_len = 8'd2;
        do_reset();
        enable = 1'b1;
        while (!scl_oe) @(negedge clk);
        stretch = 1'b1;
        while (scl_oe) @(negedge clk);
        bad = 0;
        repeat (20) begin
            if (scl_oe || scl_filt) bad++;
            @(negedge clk);
        end
        stretch = 1'b0;
        hi = 0;
        while (!scl_oe) begin if (scl_filt) hi++; @(negedge clk); end
        check("R7 released during stretch", bad, 0);
        check("R7 high window after stretch", hi, 30);
        enable = 1'b0;

        // R10 stop after enable drops during a low phase
        rst = 1'b1;
        speed_mode = 2'd1; spike_len = 8'd0;
        do_reset();
        enable = 1'b1;
        while (!scl_oe) @(negedge clk);
        enable = 1'b0;
        while (scl_oe) @(negedge clk);
        bad = 0;
        repeat (200) begin @(negedge clk); if (scl_oe) bad++; end
        check("R10 stays released", bad, 0);
        check("R10 line high", int'(scl_filt), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule